// File: doc/BRIEF.md
# Clock Synthesizer Lock Status Register

This block holds the status byte of a clock-synthesizer control unit. During reset it captures three configuration straps (clock source, multiplier style and reference source) and keeps them fixed until the next reset. It also keeps two lock indications. The first is a registered copy of the live lock signal. The second is a sticky bit. It says whether lock has held without interruption since the last reset or since the last write that actually changed the multiplier field.

The sticky bit is driven by a small state machine with these states:
- `LK_EXT`: external clock, no synthesizer in use.
- `LK_ARMED`: waiting for the first lock.
- `LK_GOOD`: lock seen and not lost.
- `LK_LOST`: lock was lost.
- `LK_STOP`: low-power stop, frozen.
- `LK_WAKE`: fast wakeup, waiting for relock.

The transitions are:
- `LK_EXT` is taken at reset when the clock strap is 0. It is never left.
- Reset with the clock strap at 1 enters `LK_ARMED`.
- `LK_ARMED` goes to `LK_GOOD` when the registered lock is 1.
- `LK_GOOD` goes to `LK_LOST` when the registered lock is 0.
- From `LK_ARMED`, `LK_GOOD` or `LK_LOST`, a multiplier change goes to `LK_ARMED`.
- From those same three states, stop entry goes to `LK_STOP` and saves the current state.
- `LK_STOP` goes back to the saved state on stop exit. If fast wakeup is enabled, it goes to `LK_WAKE` instead.
- `LK_WAKE` goes to the saved state once lock is seen. It goes back to `LK_STOP` if stop is asserted again.

Software reads the byte by pulsing `rd_stb`. The byte is captured at that clock edge and presented on `rd_data` from the next cycle. It holds there until the next read.

Top module: `clksyn_status`

## Requirements
- R1: Bits 7, 6 and 5 of the read byte show the straps `strap_pll_mode`, `strap_normal_sel` and `strap_xtal_ref` as they were sampled while `rst_n` was low. These bits do not change until the next reset, even if the straps change.
- R2: With `strap_pll_mode` at 0 during reset (external clock), bit 4 (sticky) and bit 3 (live lock) read 0 whatever the lock input does. A multiplier change does not alter this.
- R3: Bit 3 is the live lock input delayed by one register.
- R4: After a reset with `strap_pll_mode` at 1, bit 4 reads 1 once lock has been observed.
- R5: Any loss of live lock clears bit 4. Regaining lock alone leaves bit 4 at 0.
- R6: A multiplier write whose 3-bit value differs from the stored one re-arms the bit. Bit 4 then sets on the next observed lock.
- R7: A multiplier write of the value already stored does not re-arm the bit.
- R8: While `stop_mode` is high, bit 4 keeps its pre-stop value even if lock drops. After stop exit with `fast_wake_en` at 0, bit 4 keeps that value.
- R9: After stop exit with `fast_wake_en` at 1, bit 4 reads 0 until lock is observed. It then shows the pre-stop value.
- R10: A read issued in the same cycle that the lock input falls returns the previous lock and sticky values.
- R11: Bits 2 to 0 read 0. `rd_data` is 0 after reset and changes only when a read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| strap_pll_mode | input | 1 | Strap: 1 = synthesizer clock, 0 = external clock |
| strap_normal_sel | input | 1 | Strap: 1 = normal multiply, 0 = 1:1 |
| strap_xtal_ref | input | 1 | Strap: 1 = crystal reference, 0 = external reference |
| lock_live | input | 1 | Live lock from the lock detector |
| mult_wr | input | 1 | Pulse marking a write of the multiplier field |
| mult_wdata | input | MULT_W | Multiplier value being written |
| stop_mode | input | 1 | High while the chip is in stop mode |
| fast_wake_en | input | 1 | Fast wakeup enable |
| rd_stb | input | 1 | Read strobe for the status byte |
| rd_data | output | STAT_W | Captured status byte |

## Verification
A wrong state in the sticky machine appears at bit 4 on the first read issued after the error. The state advances one cycle after the registered lock, which itself lags the input by one cycle. So a read three cycles after a stimulus always reflects it. A wrongly saved pre-stop state stays hidden until stop exit, or until relock under fast wakeup, so the bench reads again after each of those events. A stuck multiplier compare shows as bit 4 staying 0 after a real change, or rising after a same-value write.

// File: rtl/clksyn_status_pkg.sv
`timescale 1ns/1ps
package clksyn_status_pkg;

    typedef enum logic [2:0] {
        LK_EXT   = 3'd0,
        LK_ARMED = 3'd1,
        LK_GOOD  = 3'd2,
        LK_LOST  = 3'd3,
        LK_STOP  = 3'd4,
        LK_WAKE  = 3'd5
    } lk_state_e;

    typedef struct packed {
        logic pll_mode;
        logic normal_sel;
        logic xtal_ref;
    } strap_t;

    // bit positions inside the status byte (a reader decodes these)
    localparam int POS_MODE   = 7;
    localparam int POS_SEL    = 6;
    localparam int POS_REF    = 5;
    localparam int POS_STICKY = 4;
    localparam int POS_LIVE   = 3;

endpackage

// File: rtl/clksyn_strap_latch.sv
`timescale 1ns/1ps
module clksyn_strap_latch
    import clksyn_status_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  strap_t strap_i,
    output strap_t strap_q
);

    // straps follow the pins during reset and freeze once it is released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_q <= strap_i;
        end
    end

endmodule

// File: rtl/clksyn_mult_track.sv
`timescale 1ns/1ps
module clksyn_mult_track #(
    parameter int MULT_W = 3,
    parameter logic [MULT_W-1:0] MULT_INIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mult_wr,
    input  logic [MULT_W-1:0] mult_wdata,
    output logic              mult_chg
);

    logic [MULT_W-1:0] mult_q;

    // only a write that really alters the field counts as a change
    assign mult_chg = mult_wr && (mult_wdata != mult_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mult_q <= MULT_INIT;
        end else if (mult_wr) begin
            mult_q <= mult_wdata;
        end
    end

endmodule

// File: rtl/clksyn_lock_fsm.sv
`timescale 1ns/1ps
module clksyn_lock_fsm
    import clksyn_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pll_mode_rst,
    input  logic      pll_mode_q,
    input  logic      lock_live,
    input  logic      mult_chg,
    input  logic      stop_mode,
    input  logic      fast_wake_en,
    output logic      lock_q,
    output logic      sticky,
    output lk_state_e state_o
);

    lk_state_e state_q, state_d;
    lk_state_e saved_q, saved_d;

    // registered live lock, forced low when no synthesizer is in use
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= lock_live & pll_mode_q;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= pll_mode_rst ? LK_ARMED : LK_EXT;
            saved_q <= LK_ARMED;
        end else begin
            state_q <= state_d;
            saved_q <= saved_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        saved_d = saved_q;
        unique case (state_q)
            LK_EXT: begin
                state_d = LK_EXT;
            end
            LK_ARMED, LK_GOOD, LK_LOST: begin
                if (stop_mode) begin
                    state_d = LK_STOP;
                    saved_d = state_q;
                end else if (mult_chg) begin
                    state_d = LK_ARMED;
                end else if (state_q == LK_ARMED && lock_q) begin
                    state_d = LK_GOOD;
                end else if (state_q == LK_GOOD && !lock_q) begin
                    state_d = LK_LOST;
                end
            end
            LK_STOP: begin
                if (!stop_mode) begin
                    state_d = fast_wake_en ? LK_WAKE : saved_q;
                end
            end
            LK_WAKE: begin
                if (stop_mode) begin
                    state_d = LK_STOP;
                end else if (lock_q) begin
                    state_d = saved_q;
                end
            end
            default: begin
                state_d = LK_EXT;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LK_GOOD: sticky = 1'b1;
            LK_STOP: sticky = (saved_q == LK_GOOD);
            default: sticky = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/clksyn_stat_pack.sv
`timescale 1ns/1ps
module clksyn_stat_pack
    import clksyn_status_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  strap_t            strap_q,
    input  logic              sticky,
    input  logic              lock_q,
    output logic [STAT_W-1:0] rd_data
);

    logic [STAT_W-1:0] byte_d;

    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        if (b == POS_MODE) begin : g_mode
            assign byte_d[b] = strap_q.pll_mode;
        end else if (b == POS_SEL) begin : g_sel
            assign byte_d[b] = strap_q.normal_sel;
        end else if (b == POS_REF) begin : g_ref
            assign byte_d[b] = strap_q.xtal_ref;
        end else if (b == POS_STICKY) begin : g_sticky
            assign byte_d[b] = sticky;
        end else if (b == POS_LIVE) begin : g_live
            assign byte_d[b] = lock_q;
        end else begin : g_zero
            assign byte_d[b] = 1'b0;
        end
    end

    // capture from registered state: a same-cycle loss shows next read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_stb) begin
            rd_data <= byte_d;
        end
    end

endmodule

// File: rtl/clksyn_status.sv
`timescale 1ns/1ps
module clksyn_status
    import clksyn_status_pkg::*;
#(
    parameter int MULT_W = 3,
    parameter logic [MULT_W-1:0] MULT_INIT = 1,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pll_mode,
    input  logic              strap_normal_sel,
    input  logic              strap_xtal_ref,
    input  logic              lock_live,
    input  logic              mult_wr,
    input  logic [MULT_W-1:0] mult_wdata,
    input  logic              stop_mode,
    input  logic              fast_wake_en,
    input  logic              rd_stb,
    output logic [STAT_W-1:0] rd_data
);

    strap_t    strap_w;
    strap_t    strap_q;
    logic      mult_chg;
    logic      lock_w;
    logic      sticky_w;
    lk_state_e state_w;

    assign strap_w = '{pll_mode: strap_pll_mode,
                       normal_sel: strap_normal_sel,
                       xtal_ref: strap_xtal_ref};

    clksyn_strap_latch u_straps (
        .clk     (clk),
        .rst_n   (rst_n),
        .strap_i (strap_w),
        .strap_q (strap_q)
    );

    clksyn_mult_track #(
        .MULT_W    (MULT_W),
        .MULT_INIT (MULT_INIT)
    ) u_mult (
        .clk        (clk),
        .rst_n      (rst_n),
        .mult_wr    (mult_wr),
        .mult_wdata (mult_wdata),
        .mult_chg   (mult_chg)
    );

    clksyn_lock_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pll_mode_rst (strap_pll_mode),
        .pll_mode_q   (strap_q.pll_mode),
        .lock_live    (lock_live),
        .mult_chg     (mult_chg),
        .stop_mode    (stop_mode),
        .fast_wake_en (fast_wake_en),
        .lock_q       (lock_w),
        .sticky       (sticky_w),
        .state_o      (state_w)
    );

    clksyn_stat_pack #(
        .STAT_W (STAT_W)
    ) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_stb  (rd_stb),
        .strap_q (strap_q),
        .sticky  (sticky_w),
        .lock_q  (lock_w),
        .rd_data (rd_data)
    );

endmodule

module clksyn_status_chk
    import clksyn_status_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_mode,
    input logic              rd_stb,
    input logic [STAT_W-1:0] rd_data,
    input strap_t            strap_q,
    input logic              sticky,
    input logic              lock_q,
    input lk_state_e         state
);

    // R1
    straps_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(strap_q));

    // R2
    ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strap_q.pll_mode |-> (!sticky && !lock_q));

    // R5
    loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_GOOD && !lock_q && !stop_mode) |=> !sticky);

    // R4
    set_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sticky) && !$past(stop_mode)) |-> $past(lock_q));

    // R9
    wake_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == LK_WAKE) |-> !sticky);

    // R10
    read_old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (rd_data[POS_STICKY] == $past(sticky) &&
                    rd_data[POS_LIVE] == $past(lock_q)));

    // R11
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    // R11
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2:0] == 3'b000);

endmodule

bind clksyn_status clksyn_status_chk #(.STAT_W(STAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_mode (stop_mode),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .strap_q   (strap_q),
    .sticky    (sticky_w),
    .lock_q    (lock_w),
    .state     (state_w)
);

// File: tb/clksyn_status_tb.sv
`timescale 1ns/1ps
module clksyn_status_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_pll_mode = 1'b1;
    logic       strap_normal_sel = 1'b1;
    logic       strap_xtal_ref = 1'b0;
    logic       lock_live = 1'b1;
    logic       mult_wr = 1'b0;
    logic [2:0] mult_wdata = 3'd0;
    logic       stop_mode = 1'b0;
    logic       fast_wake_en = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    clksyn_status u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .strap_pll_mode   (strap_pll_mode),
        .strap_normal_sel (strap_normal_sel),
        .strap_xtal_ref   (strap_xtal_ref),
        .lock_live        (lock_live),
        .mult_wr          (mult_wr),
        .mult_wdata       (mult_wdata),
        .stop_mode        (stop_mode),
        .fast_wake_en     (fast_wake_en),
        .rd_stb           (rd_stb),
        .rd_data          (rd_data)
    );

    task automatic check(input logic [7:0] exp, input string req);
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, rd_data, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_chk(input logic [7:0] exp, input string req);
        rd_stb = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_stb = 1'b0;
        check(exp, req);
    endtask

    task automatic mult_write(input logic [2:0] v);
        mult_wdata = v;
        mult_wr = 1'b1;
        @(negedge clk);
        mult_wr = 1'b0;
    endtask

    task automatic do_reset(input logic pm, input logic ns, input logic xr);
        @(negedge clk);
        rst_n = 1'b0;
        strap_pll_mode = pm;
        strap_normal_sel = ns;
        strap_xtal_ref = xr;
        wait_n(3);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_pll;
        do_reset(1'b1, 1'b1, 1'b0);
        check(8'h00, "R11 reset value");
        wait_n(3);
        read_chk(8'b110_1_1_000, "R4 R1 R3 after reset");
    endtask

    task automatic t_loss_relock;
        lock_live = 1'b0;
        wait_n(3);
        read_chk(8'b110_0_0_000, "R5 loss");
        lock_live = 1'b1;
        wait_n(3);
        read_chk(8'b110_0_1_000, "R5 relock alone");
    endtask

    task automatic t_mult;
        mult_write(3'd1);
        wait_n(3);
        read_chk(8'b110_0_1_000, "R7 same value");
        mult_write(3'd2);
        wait_n(3);
        read_chk(8'b110_1_1_000, "R6 changed value");
    endtask

    task automatic t_same_cycle_read;
        lock_live = 1'b0;
        read_chk(8'b110_1_1_000, "R10 same cycle read");
        wait_n(3);
        read_chk(8'b110_0_0_000, "R10 later read");
        lock_live = 1'b1;
        wait_n(2);
        mult_write(3'd3);
        wait_n(3);
        read_chk(8'b110_1_1_000, "R6 rearm again");
    endtask

    task automatic t_hold;
        lock_live = 1'b0;
        wait_n(4);
        check(8'b110_1_1_000, "R11 hold without read");
        lock_live = 1'b1;
        wait_n(2);
        mult_write(3'd4);
        wait_n(3);
        read_chk(8'b110_1_1_000, "R6 rearm after hold");
    endtask

    task automatic t_stop_plain;
        fast_wake_en = 1'b0;
        stop_mode = 1'b1;
        wait_n(2);
        lock_live = 1'b0;
        wait_n(3);
        read_chk(8'b110_1_0_000, "R8 in stop");
        lock_live = 1'b1;
        wait_n(2);
        stop_mode = 1'b0;
        wait_n(3);
        read_chk(8'b110_1_1_000, "R8 after exit");
    endtask

    task automatic t_stop_fast;
        fast_wake_en = 1'b1;
        stop_mode = 1'b1;
        wait_n(2);
        lock_live = 1'b0;
        wait_n(2);
        stop_mode = 1'b0;
        wait_n(3);
        read_chk(8'b110_0_0_000, "R9 wake no lock");
        lock_live = 1'b1;
        wait_n(3);
        read_chk(8'b110_1_1_000, "R9 relock restores");
        lock_live = 1'b0;
        wait_n(2);
        lock_live = 1'b1;
        wait_n(3);
        stop_mode = 1'b1;
        wait_n(2);
        lock_live = 1'b0;
        wait_n(2);
        stop_mode = 1'b0;
        wait_n(2);
        lock_live = 1'b1;
        wait_n(3);
        read_chk(8'b110_0_1_000, "R9 restores lost");
        fast_wake_en = 1'b0;
    endtask

    task automatic t_ext;
        lock_live = 1'b1;
        do_reset(1'b0, 1'b1, 1'b1);
        wait_n(3);
        read_chk(8'b011_0_0_000, "R2 R1 external");
        strap_pll_mode = 1'b1;
        strap_normal_sel = 1'b0;
        strap_xtal_ref = 1'b0;
        mult_write(3'd6);
        wait_n(3);
        read_chk(8'b011_0_0_000, "R1 R2 straps frozen");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_pll();
        t_loss_relock();
        t_mult();
        t_same_cycle_read();
        t_hold();
        t_stop_plain();
        t_stop_fast();
        t_ext();
        wait_n(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule